// File: doc/BRIEF.md
# Timestamped Virtual Channel Link Queue

This block stands for one link of a network that is simulated in virtual time. Flit descriptors arrive with a virtual channel number and the time at which they reached the link. Each descriptor is written into a storage region that belongs to its channel. On the way in, its time field is replaced by the time at which the flit may leave the far end of the link. That departure time takes the link's per-step bandwidth limit and its configured latency into account.

Every channel has its own output. A channel offers its oldest flit only once the global simulation time has caught up with that flit's departure time. The timing state is a pass count and the previous flit's departure time before latency. This state is shared by all channels of the link, because they compete for the same wire. Latency and bandwidth are input ports, so the link can be retimed at run time without rebuilding the design.

Top module: `tsvc_link_queue`

## Requirements
- R1: After reset every `in_ready` bit is 1, every `out_valid` bit is 0 and every `vc_full` bit is 0.
- R2: An accepted flit is stored in the queue selected by its channel field, bits [TS_W+VC_W-1:TS_W]. Each channel delivers its flits in arrival order, and other channels are not affected.
- R3: A channel holding DEPTH flits drives `in_ready`=0 and `vc_full`=1. A flit offered to that channel is not stored.
- R4: On each accepted flit the pass count is first incremented. If the arrival time is later than the stored last-flit time, or the incremented count is at least `cfg_bandwidth`, the departure time becomes the later of the arrival time and last-flit time + 1, and the count restarts at 1.
- R5: In every other case the departure time equals the arrival time.
- R6: The stored time field, bits [TS_W-1:0], equals the departure time plus `cfg_latency`. All other bits pass through unchanged.
- R7: The last-flit time is the previous flit's departure time before latency, shared across all channels. Reset sets it to 0 and the pass count to 0.
- R8: `out_valid[v]` is 1 exactly when channel v is non-empty and `sim_time` minus the head's time field, taken modulo 2^TS_W, has its top bit clear. A flit leaves when `out_valid[v]` and `out_ready[v]` are both 1.
- R9: `cfg_latency` and `cfg_bandwidth` are sampled when a flit is accepted. Later changes do not alter flits that are already stored.
- R10: All time comparisons use the sign of the difference modulo 2^TS_W, so departure times and release stay correct across the wrap of the time counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latency | input | TS_W | Link latency in time steps |
| cfg_bandwidth | input | BW_W | Flits allowed per time step |
| sim_time | input | TS_W | Global simulation time |
| in_valid | input | 1 | Descriptor on `in_flit` is offered |
| in_flit | input | FLIT_W | Incoming descriptor (time in low bits, channel above it) |
| in_ready | output | NUM_VC | Per-channel space available |
| out_valid | output | NUM_VC | Per-channel head flit is due |
| out_ready | input | NUM_VC | Per-channel consumer takes the head |
| out_flit | output | NUM_VC*FLIT_W | Per-channel head descriptor, channel v at bits [v*FLIT_W +: FLIT_W] |
| vc_full | output | NUM_VC | Per-channel queue full |

## Verification
The bench builds the block with two channels of depth four, a 4-bit bandwidth field and the package's 16-bit time. With these values a channel can be filled to overflow in a handful of cycles. A bandwidth of three forces the count restart inside one time step. The bench also drives `sim_time` to within a few steps of 0xFFFF, so that stamps and release cross the wrap in a short run. Random traffic with time moving forward slowly then mixes early, same-step and late arrivals across both channels while latency and bandwidth change underneath.

// File: rtl/tsvc_pkg.sv
package tsvc_pkg;

    parameter int TS_W = 16;

    typedef logic [TS_W-1:0] ts_t;

    // a strictly after b, by sign of the wrapped difference
    function automatic logic ts_later(ts_t a, ts_t b);
        ts_t diff;
        diff = a - b;
        return !diff[TS_W-1] && (diff != '0);
    endfunction

    // now at or past stamp, by sign of the wrapped difference
    function automatic logic ts_reached(ts_t now, ts_t stamp);
        ts_t diff;
        diff = now - stamp;
        return !diff[TS_W-1];
    endfunction

endpackage

// File: rtl/tsvc_stamp.sv
module tsvc_stamp
    import tsvc_pkg::*;
#(
    parameter int BW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enq_fire,
    input  ts_t             enq_ts,
    input  ts_t             cfg_lat,
    input  logic [BW_W-1:0] cfg_bw,
    output ts_t             out_ts
);

    localparam int CNT_W = BW_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ts_t              last;
    } stamp_st_t;

    stamp_st_t st_d, st_q;

    always_comb begin
        logic [CNT_W-1:0] n;
        ts_t              deq;
        ts_t              nxt;
        st_d = st_q;
        n    = st_q.cnt + CNT_W'(1);
        nxt  = st_q.last + ts_t'(1);
        if (ts_later(enq_ts, st_q.last) || (n >= CNT_W'(cfg_bw))) begin
            deq = ts_later(enq_ts, nxt) ? enq_ts : nxt;
            n   = CNT_W'(1);
        end else begin
            deq = enq_ts;
        end
        out_ts = deq + cfg_lat;
        if (enq_fire) begin
            st_d.cnt  = n;
            st_d.last = deq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a counted flit leaves the count non-zero
    p_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |=> (st_q.cnt != '0));

    // R6: the outgoing stamp never precedes arrival plus latency
    p_stamp_after_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |-> !ts_later(enq_ts + cfg_lat, out_ts));

    // R7: in-order arrivals never move the last-flit time backwards
    p_last_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire && !ts_later(st_q.last, enq_ts)) |=> !ts_later($past(st_q.last), st_q.last));

endmodule

// File: rtl/tsvc_vc_store.sv
module tsvc_vc_store #(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 4,
    parameter int FLIT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [VC_W-1:0]                wr_vc,
    input  logic [FLIT_W-1:0]              wr_flit,
    input  logic [NUM_VC-1:0]              rd_en,
    output logic [NUM_VC-1:0][FLIT_W-1:0]  head,
    output logic [NUM_VC-1:0]              empty,
    output logic [NUM_VC-1:0]              full
);

    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SLOTS = NUM_VC * DEPTH;

    typedef struct packed {
        logic [SLOTS-1:0][FLIT_W-1:0]  mem;
        logic [NUM_VC-1:0][PTR_W-1:0]  wp;
        logic [NUM_VC-1:0][PTR_W-1:0]  rp;
        logic [NUM_VC-1:0][CNT_W-1:0]  cnt;
    } store_st_t;

    store_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_adv(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        for (int v = 0; v < NUM_VC; v++) begin
            logic push;
            logic pop;
            push = wr_en && (wr_vc == VC_W'(v)) && (int'(st_q.cnt[v]) < DEPTH);
            pop  = rd_en[v] && (st_q.cnt[v] != '0);
            if (push) begin
                st_d.mem[v*DEPTH + int'(st_q.wp[v])] = wr_flit;
                st_d.wp[v] = ptr_adv(st_q.wp[v]);
            end
            if (pop) begin
                st_d.rp[v] = ptr_adv(st_q.rp[v]);
            end
            st_d.cnt[v] = st_q.cnt[v] + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        assign head[g]  = st_q.mem[g*DEPTH + int'(st_q.rp[g])];
        assign empty[g] = (st_q.cnt[g] == '0);
        assign full[g]  = (int'(st_q.cnt[g]) == DEPTH);

        // R2: a channel is never read while empty
        p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[g] |-> !empty[g]);

        // R3: fill level stays inside the region
        p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(st_q.cnt[g]) <= DEPTH);

        // R3: no write lands on a full channel
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_vc == VC_W'(g)) |-> !full[g]);
    end

endmodule

// File: rtl/tsvc_link_queue.sv
module tsvc_link_queue
    import tsvc_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 4,
    parameter int FLIT_W = 32,
    parameter int BW_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TS_W-1:0]          cfg_latency,
    input  logic [BW_W-1:0]          cfg_bandwidth,
    input  logic [TS_W-1:0]          sim_time,
    input  logic                     in_valid,
    input  logic [FLIT_W-1:0]        in_flit,
    output logic [NUM_VC-1:0]        in_ready,
    output logic [NUM_VC-1:0]        out_valid,
    input  logic [NUM_VC-1:0]        out_ready,
    output logic [NUM_VC*FLIT_W-1:0] out_flit,
    output logic [NUM_VC-1:0]        vc_full
);

    localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

    logic [VC_W-1:0]                 in_vc;
    ts_t                             enq_ts;
    ts_t                             stamp;
    logic                            vc_ok;
    logic                            accept;
    logic [NUM_VC-1:0]               rd_en;
    logic [NUM_VC-1:0]               q_empty;
    logic [NUM_VC-1:0]               q_full;
    logic [NUM_VC-1:0][FLIT_W-1:0]   q_head;
    logic [FLIT_W-1:0]               wr_flit;

    assign in_vc  = in_flit[TS_W +: VC_W];
    assign enq_ts = in_flit[TS_W-1:0];

    if (NUM_VC == (1 << VC_W)) begin : g_vc_dense
        assign vc_ok = 1'b1;
    end else begin : g_vc_sparse
        assign vc_ok = (int'(in_vc) < NUM_VC);
    end

    assign accept  = in_valid && vc_ok && in_ready[in_vc];
    assign wr_flit = {in_flit[FLIT_W-1:TS_W], stamp};

    tsvc_stamp #(.BW_W(BW_W)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_fire (accept),
        .enq_ts   (enq_ts),
        .cfg_lat  (cfg_latency),
        .cfg_bw   (cfg_bandwidth),
        .out_ts   (stamp)
    );

    tsvc_vc_store #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .FLIT_W(FLIT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_vc   (in_vc),
        .wr_flit (wr_flit),
        .rd_en   (rd_en),
        .head    (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    for (genvar g = 0; g < NUM_VC; g++) begin : g_out
        assign out_valid[g] = !q_empty[g] && ts_reached(sim_time, q_head[g][TS_W-1:0]);
        assign out_flit[g*FLIT_W +: FLIT_W] = q_head[g];

        // R8: a due head not taken stays due unless time moved back
        p_hold_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && !out_ready[g]) |=>
                (out_valid[g] || ts_later($past(sim_time), sim_time)));

        // R2: a head that is not taken keeps its contents
        p_head_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && !out_ready[g]) |=> $stable(out_flit[g*FLIT_W +: FLIT_W]));
    end

    assign rd_en    = out_valid & out_ready;
    assign in_ready = ~q_full;
    assign vc_full  = q_full;

endmodule

// File: tb/tsvc_link_queue_bench.sv
module tsvc_link_queue_bench;
    import tsvc_pkg::*;

    localparam int NV  = 2;
    localparam int DP  = 4;
    localparam int FW  = 32;
    localparam int BWW = 4;
    localparam int MOD = 65536;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [TS_W-1:0]   cfg_latency;
    logic [BWW-1:0]    cfg_bandwidth;
    logic [TS_W-1:0]   sim_time;
    logic              in_valid;
    logic [FW-1:0]     in_flit;
    logic [NV-1:0]     in_ready;
    logic [NV-1:0]     out_valid;
    logic [NV-1:0]     out_ready;
    logic [NV*FW-1:0]  out_flit;
    logic [NV-1:0]     vc_full;

    tsvc_link_queue u_tsvc_link_queue (
        .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_bandwidth(cfg_bandwidth),
        .sim_time(sim_time), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .vc_full(vc_full)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "init";

    // behavioural reference
    logic [FW-1:0] mq [NV][$];
    int m_cnt;
    int m_last;
    int now;
    int lat_cur;
    int bw_cur;
    int taken1;

    function automatic bit m_later(int a, int b);
        int d = ((a - b) % MOD + MOD) % MOD;
        return (d != 0) && (d < MOD / 2);
    endfunction

    function automatic bit m_reached(int t, int s);
        int d = ((t - s) % MOD + MOD) % MOD;
        return d < MOD / 2;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s): actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int v = 0; v < NV; v++) mq[v].delete();
        m_cnt  = 0;
        m_last = 0;
    endtask

    task automatic m_push(logic [FW-1:0] f);
        int te = int'(f[15:0]);
        int n  = m_cnt + 1;
        int nx = (m_last + 1) % MOD;
        int dq;
        if (m_later(te, m_last) || n >= bw_cur) begin
            dq = m_later(te, nx) ? te : nx;
            n  = 1;
        end else begin
            dq = te;
        end
        m_last = dq;
        m_cnt  = n;
        f[15:0] = 16'((dq + lat_cur) % MOD);
        mq[int'(f[16])].push_back(f);
    endtask

    task automatic compare_all();
        for (int v = 0; v < NV; v++) begin
            bit ev = (mq[v].size() > 0) && m_reached(now, int'(mq[v][0][15:0]));
            check("R8 out_valid", 64'(out_valid[v]), 64'(ev));
            if (ev) check("R6 out_flit", 64'(out_flit[v*FW +: FW]), 64'(mq[v][0]));
            check("R3 in_ready", 64'(in_ready[v]), 64'(mq[v].size() < DP));
            check("R3 vc_full", 64'(vc_full[v]), 64'(mq[v].size() == DP));
        end
    endtask

    task automatic drive(bit v_in, int vc, int ts, int pay, logic [NV-1:0] rdy);
        @(negedge clk);
        sim_time      = 16'(now);
        cfg_latency   = 16'(lat_cur);
        cfg_bandwidth = 4'(bw_cur);
        in_valid      = v_in;
        in_flit       = {15'(pay), 1'(vc), 16'(ts)};
        out_ready     = rdy;
        #1;
        compare_all();
        begin
            bit pop [NV];
            bit push_ok;
            for (int v = 0; v < NV; v++)
                pop[v] = rdy[v] && (mq[v].size() > 0) && m_reached(now, int'(mq[v][0][15:0]));
            push_ok = v_in && (mq[vc].size() < DP);
            if (pop[1]) taken1++;
            for (int v = 0; v < NV; v++) if (pop[v]) void'(mq[v].pop_front());
            if (push_ok) m_push(in_flit);
        end
    endtask

    task automatic idle(logic [NV-1:0] rdy);
        drive(0, 0, 0, 0, rdy);
    endtask

    // look at the ports without accepting anything at the following edge
    task automatic peek();
        @(negedge clk);
        sim_time  = 16'(now);
        in_valid  = 1'b0;
        out_ready = '0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        out_ready = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b0; in_flit = '0; out_ready = '0;
        now = 5; lat_cur = 3; bw_cur = 3; taken1 = 0;
        sim_time = 16'(now); cfg_latency = 16'(lat_cur); cfg_bandwidth = 4'(bw_cur);
        do_reset();

        // R1: reset state
        phase = "R1";
        peek();
        check("R1 in_ready", 64'(in_ready), 64'(2'b11));
        check("R1 out_valid", 64'(out_valid), 64'(2'b00));
        check("R1 vc_full", 64'(vc_full), 64'(2'b00));

        // R4 / R5 / R7: bandwidth three, latency three, arrivals at 10
        phase = "R4";
        drive(1, 0, 10, 11, 2'b00);   // later than 0 -> dep 10, stamp 13
        drive(1, 0, 10, 12, 2'b00);   // count 2 -> dep 10 (R5), stamp 13
        drive(1, 0, 10, 13, 2'b00);   // count 3 hits limit -> dep 11, stamp 14
        drive(1, 1, 12, 14, 2'b00);   // later than 11 -> dep 12, stamp 15 (R7 shared)
        peek();
        check("R4 head vc0 stamp", 64'(out_flit[15:0]), 64'd13);
        check("R7 head vc1 stamp", 64'(out_flit[FW +: 16]), 64'd15);
        check("R6 payload vc0", 64'(out_flit[31:17]), 64'd11);
        check("R8 not due at 5", 64'(out_valid), 64'd0);

        // R9: retune before release; stored stamps must not move
        phase = "R9";
        lat_cur = 7; bw_cur = 1;
        now = 12; idle(2'b00);
        now = 13; idle(2'b00);
        peek();
        check("R8 vc0 due at 13", 64'(out_valid[0]), 64'd1);
        check("R9 stamp kept", 64'(out_flit[15:0]), 64'd13);
        // drain in order (R2)
        phase = "R2";
        now = 14; idle(2'b01); idle(2'b01);
        peek();
        check("R2 third vc0 flit", 64'(out_flit[31:0]), 64'({15'd13, 1'b0, 16'd14}));
        idle(2'b01);
        now = 15; idle(2'b11); idle(2'b11);

        // R3: overflow one channel
        phase = "R3";
        lat_cur = 2; bw_cur = 4;
        now = 20;
        for (int i = 0; i < 6; i++) drive(1, 1, 30 + i, 100 + i, 2'b00);
        peek();
        check("R3 vc1 full", 64'(vc_full[1]), 64'd1);
        check("R3 vc1 ready low", 64'(in_ready[1]), 64'd0);
        check("R3 vc0 still ready", 64'(in_ready[0]), 64'd1);
        taken1 = 0;
        now = 60;
        for (int i = 0; i < 8; i++) idle(2'b10);
        check("R3 only depth delivered", 64'(taken1), 64'(DP));

        // R10: wrap of time
        phase = "R10";
        do_reset();
        lat_cur = 5; bw_cur = 2;
        now = 65520;
        drive(1, 0, 16'h4000, 1, 2'b01);
        drive(1, 0, 16'h8000, 2, 2'b01);
        drive(1, 0, 16'hC000, 3, 2'b01);
        drive(1, 1, 16'hFFFB, 4, 2'b01);   // dep FFFB + 5 wraps to 0000
        idle(2'b01);
        now = 65535;
        peek();
        check("R10 wrapped stamp", 64'(out_flit[FW +: 16]), 64'd0);
        check("R10 not due at FFFF", 64'(out_valid[1]), 64'd0);
        now = 0;
        peek();
        check("R10 due after wrap", 64'(out_valid[1]), 64'd1);
        idle(2'b11);

        // mixed traffic around the wrap, compared every clock
        phase = "R2 random";
        now = 65400;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 2) == 0) now = (now + 1) % MOD;
            if ($urandom_range(0, 40) == 0) lat_cur = $urandom_range(0, 4);
            if ($urandom_range(0, 40) == 0) bw_cur = $urandom_range(0, 4);
            drive($urandom_range(0, 1), $urandom_range(0, 1),
                  (now + $urandom_range(0, 3)) % MOD, $urandom_range(0, 32767),
                  2'($urandom_range(0, 3)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule